// File: doc/BRIEF.md
# USB IN Endpoint Transmit Handler

This block is the transmit half of a USB device core. One shared byte FIFO, 64 entries deep by default, holds the next outgoing packet. Software fills the FIFO through a byte-write port. It then arms the packet for one endpoint out of sixteen with a control write. When the already-decoded token interface presents an IN token, the block chooses one of three replies: DATA, NAK or STALL. For DATA it streams the payload to the serializer over a valid/ready handshake, then raises a one-cycle request for the serializer to append the CRC16.

The block does not clear the packet when it finishes sending. The packet stays queued until the host's handshake arrives. An ACK frees the FIFO, disarms the endpoint and raises a done event. A timeout rewinds the read index, so the same bytes go out again on the next IN token. Each endpoint has its own stall flag. Software sets and clears that flag, and a SETUP token to the endpoint also clears it.

Top module: `usb_in_tx`

## Requirements
- R1: A data write pushes one byte when the FIFO is idle, unarmed and not full. `stat_have` reads 1 from the cycle after the first accepted byte. Writes beyond DEPTH bytes are dropped.
- R2: An IN token gets a NAK reply (`rsp_kind` = 2'b01) when its endpoint is not stalled and either nothing is armed or the armed endpoint differs.
- R3: An IN token to the armed, unstalled endpoint gets a DATA reply (`rsp_kind` = 2'b11). The reply is presented one cycle after the token. The payload streams in the same cycle, in write order, with `tx_last` on the final byte. A bus stall holds `tx_valid` and `tx_data` steady. `tx_crc_req` pulses for one cycle after the last byte is accepted. A zero-length packet raises `tx_crc_req` in the reply cycle and moves no bytes.
- R4: `hs_ack` while awaiting the handshake empties the FIFO, disarms the endpoint, sets `stat_idle`, and pulses `ev_raw`.
- R5: `hs_timeout` while awaiting the handshake keeps the packet armed, and the next matching IN token sends the same bytes again.
- R6: A control write with flush=0 sets endpoint `sw_ctrl_ep`'s stall flag to `sw_ctrl_stall`. A write with the stall bit clear also arms that endpoint. A stalled endpoint gets a STALL reply (`rsp_kind` = 2'b10), even when it is armed.
- R7: A SETUP token clears the stall flag of the endpoint it names.
- R8: A control write with `sw_ctrl_flush`=1 empties the FIFO and disarms the endpoint, and leaves the stall flags unchanged.
- R9: `stat_pend` sets on a done event and clears on `ev_pend_clr`. `irq` is `stat_pend` AND the enable bit loaded by `ev_en_we`.
- R10: The FIFO ignores data writes while a packet is armed. While a packet is being sent or awaits its handshake, the block ignores data writes, control writes and IN tokens (no reply).
- R11: After reset, `stat_idle`=1, `stat_have`=0, `stat_pend`=0 and `irq`=0, no endpoint is stalled, and no reply or byte is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_data_we | input | 1 | Push strobe for the byte on sw_data |
| sw_data | input | DATA_W | Byte to queue |
| sw_ctrl_we | input | 1 | Control write strobe |
| sw_ctrl_ep | input | EP_W | Endpoint to arm or to update the stall flag of |
| sw_ctrl_stall | input | 1 | New stall flag value; 0 also arms |
| sw_ctrl_flush | input | 1 | Empty FIFO and disarm instead |
| ev_pend_clr | input | 1 | Clear the pending done event |
| ev_en_we | input | 1 | Load the event enable bit |
| ev_en_d | input | 1 | Event enable value |
| stat_idle | output | 1 | No packet armed or in flight |
| stat_have | output | 1 | FIFO holds at least one byte |
| stat_pend | output | 1 | Done event pending |
| ev_raw | output | 1 | Done event level (one cycle on ACK) |
| irq | output | 1 | Pending and enabled |
| tok_in_valid | input | 1 | IN token strobe |
| tok_setup_valid | input | 1 | SETUP token strobe |
| tok_ep | input | EP_W | Token endpoint number |
| rsp_valid | output | 1 | Reply kind is valid this cycle |
| rsp_kind | output | 2 | 01 NAK, 10 STALL, 11 DATA |
| tx_valid | output | 1 | Payload byte valid |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_data | output | DATA_W | Payload byte |
| tx_last | output | 1 | Final payload byte |
| tx_crc_req | output | 1 | Append CRC16 now |
| hs_ack | input | 1 | Host acknowledged the packet |
| hs_timeout | input | 1 | Host handshake missing |

## Verification
Most bad internal states here show up at the ports by the next IN token. A stale read index or count sends the wrong bytes, too many or too few, or puts `tx_last` on the wrong byte one cycle after the token. A wrong stall flag or armed endpoint makes `rsp_kind` wrong in the same reply cycle. A bad flush or ACK cleanup shows on `stat_have` and `stat_idle` one cycle after the write or ACK. It also turns the next reply into DATA where NAK was expected. An event path fault shows on `stat_pend` and `irq` within one cycle of the ACK or clear.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;
   typedef enum logic [1:0] {
      RSP_NONE  = 2'b00,
      RSP_NAK   = 2'b01,
      RSP_STALL = 2'b10,
      RSP_DATA  = 2'b11
   } rsp_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2
   } tx_st_e;
endpackage

// File: rtl/usb_in_fifo.sv
// Packet buffer: bytes are written from index 0 upward and read by a
// separate index that can be rewound, so a packet survives until freed.
module usb_in_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            push,
   input  logic [DATA_W-1:0]               push_data,
   input  logic                            clear,
   input  logic                            rd_rewind,
   input  logic                            rd_adv,
   output logic [$clog2(DEPTH+1)-1:0]      count,
   output logic [$clog2(DEPTH+1)-1:0]      rd_idx,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            full
);
   localparam int AW    = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  rd_q;

   assign full    = (count_q == CNT_W'(DEPTH));
   assign count   = count_q;
   assign rd_idx  = rd_q;
   assign rd_data = mem[rd_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !full) begin
         mem[count_q[AW-1:0]] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clear) begin
         count_q <= '0;
      end else if (push && !full) begin
         count_q <= count_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_rewind || clear) begin
         rd_q <= '0;
      end else if (rd_adv) begin
         rd_q <= rd_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/usb_in_stall_tbl.sv
// One stall flag per endpoint; software writes win over a same-cycle SETUP.
module usb_in_stall_tbl #(
   parameter int EP_CNT       = 16,
   parameter bit CLR_ON_SETUP = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      set_we,
   input  logic [$clog2(EP_CNT)-1:0] set_ep,
   input  logic                      set_val,
   input  logic                      setup_valid,
   input  logic [$clog2(EP_CNT)-1:0] setup_ep,
   output logic [EP_CNT-1:0]         stall_vec
);
   localparam int EP_W = $clog2(EP_CNT);

   logic clr_hit;

   generate
      if (CLR_ON_SETUP) begin : g_setup_clr
         assign clr_hit = setup_valid;
      end else begin : g_setup_keep
         assign clr_hit = 1'b0;
      end
   endgenerate

   generate
      for (genvar e = 0; e < EP_CNT; e++) begin : g_ep
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else if (set_we && set_ep == EP_W'(e)) begin
               flag_q <= set_val;
            end else if (clr_hit && setup_ep == EP_W'(e)) begin
               flag_q <= 1'b0;
            end
         end
         assign stall_vec[e] = flag_q;
      end
   endgenerate
endmodule

// File: rtl/usb_in_event.sv
// Done event: sticky pending bit, enable bit, interrupt.
module usb_in_event (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic pend_clr,
   input  logic en_we,
   input  logic en_d,
   output logic pend,
   output logic irq
);
   logic pend_q;
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (raw) begin
         pend_q <= 1'b1;
      end else if (pend_clr) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (en_we) begin
         en_q <= en_d;
      end
   end

   assign pend = pend_q;
   assign irq  = pend_q & en_q;
endmodule

// File: rtl/usb_in_tx.sv
module usb_in_tx
   import usb_in_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int DEPTH        = 64,
   parameter int EP_CNT       = 16,
   parameter bit CLR_ON_SETUP = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sw_data_we,
   input  logic [DATA_W-1:0]         sw_data,
   input  logic                      sw_ctrl_we,
   input  logic [$clog2(EP_CNT)-1:0] sw_ctrl_ep,
   input  logic                      sw_ctrl_stall,
   input  logic                      sw_ctrl_flush,
   input  logic                      ev_pend_clr,
   input  logic                      ev_en_we,
   input  logic                      ev_en_d,
   output logic                      stat_idle,
   output logic                      stat_have,
   output logic                      stat_pend,
   output logic                      ev_raw,
   output logic                      irq,
   input  logic                      tok_in_valid,
   input  logic                      tok_setup_valid,
   input  logic [$clog2(EP_CNT)-1:0] tok_ep,
   output logic                      rsp_valid,
   output logic [1:0]                rsp_kind,
   output logic                      tx_valid,
   input  logic                      tx_ready,
   output logic [DATA_W-1:0]         tx_data,
   output logic                      tx_last,
   output logic                      tx_crc_req,
   input  logic                      hs_ack,
   input  logic                      hs_timeout
);
   localparam int EP_W  = $clog2(EP_CNT);
   localparam int CNT_W = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("usb_in_tx: DEPTH must be a power of two of at least 2");
      end
      if (EP_CNT < 2 || (EP_CNT & (EP_CNT - 1)) != 0) begin : g_bad_ep
         $error("usb_in_tx: EP_CNT must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("usb_in_tx: DATA_W must be positive");
      end
   endgenerate

   tx_st_e            st_q;
   logic              armed_q;
   logic [EP_W-1:0]   armed_ep_q;
   logic              rsp_valid_q;
   rsp_e              rsp_kind_q;

   logic [CNT_W-1:0]  fifo_count;
   logic [CNT_W-1:0]  rd_idx;
   logic [DATA_W-1:0] rd_data;
   logic              fifo_full;
   logic [EP_CNT-1:0] stall_vec;

   logic busy;
   logic push;
   logic ctrl_ok;
   logic flush;
   logic stall_we;
   logic arm_set;
   logic in_hit;
   rsp_e kind_c;
   logic send_done;
   logic rd_adv;
   logic ack_hit;
   logic to_hit;

   // software side
   assign busy     = (st_q != ST_IDLE);
   assign push     = sw_data_we && !busy && !armed_q;
   assign ctrl_ok  = sw_ctrl_we && !busy;
   assign flush    = ctrl_ok && sw_ctrl_flush;
   assign stall_we = ctrl_ok && !sw_ctrl_flush;
   assign arm_set  = stall_we && !sw_ctrl_stall;

   // token side: stall first, then endpoint match, otherwise NAK
   assign in_hit = tok_in_valid && (st_q == ST_IDLE);
   always_comb begin
      if (stall_vec[tok_ep]) begin
         kind_c = RSP_STALL;
      end else if (armed_q && tok_ep == armed_ep_q) begin
         kind_c = RSP_DATA;
      end else begin
         kind_c = RSP_NAK;
      end
   end

   // payload stream
   assign send_done = (st_q == ST_SEND) && (rd_idx == fifo_count);
   assign tx_valid  = (st_q == ST_SEND) && (rd_idx != fifo_count);
   assign tx_data   = rd_data;
   assign tx_last   = tx_valid && ((rd_idx + CNT_W'(1)) == fifo_count);
   assign rd_adv    = tx_valid && tx_ready;
   assign tx_crc_req = send_done;

   // host handshake
   assign ack_hit = (st_q == ST_WAIT) && hs_ack;
   assign to_hit  = (st_q == ST_WAIT) && hs_timeout && !hs_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (in_hit && kind_c == RSP_DATA) st_q <= ST_SEND;
            ST_SEND: if (send_done) st_q <= ST_WAIT;
            ST_WAIT: if (ack_hit || to_hit) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         armed_ep_q <= '0;
      end else if (flush || ack_hit) begin
         armed_q    <= 1'b0;
      end else if (arm_set) begin
         armed_q    <= 1'b1;
         armed_ep_q <= sw_ctrl_ep;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_kind_q  <= RSP_NONE;
      end else begin
         rsp_valid_q <= in_hit;
         rsp_kind_q  <= in_hit ? kind_c : RSP_NONE;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_kind  = rsp_kind_q;
   assign stat_idle = !busy && !armed_q;
   assign stat_have = (fifo_count != '0);
   assign ev_raw    = ack_hit;

   usb_in_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (sw_data),
      .clear     (flush || ack_hit),
      .rd_rewind (to_hit),
      .rd_adv    (rd_adv),
      .count     (fifo_count),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .full      (fifo_full)
   );

   usb_in_stall_tbl #(
      .EP_CNT       (EP_CNT),
      .CLR_ON_SETUP (CLR_ON_SETUP)
   ) u_stall (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_we      (stall_we),
      .set_ep      (sw_ctrl_ep),
      .set_val     (sw_ctrl_stall),
      .setup_valid (tok_setup_valid),
      .setup_ep    (tok_ep),
      .stall_vec   (stall_vec)
   );

   usb_in_event u_event (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (ack_hit),
      .pend_clr (ev_pend_clr),
      .en_we    (ev_en_we),
      .en_d     (ev_en_d),
      .pend     (stat_pend),
      .irq      (irq)
   );
endmodule

// File: rtl/usb_in_tx_chk.sv
module usb_in_tx_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       tx_valid,
   input logic                       tx_ready,
   input logic [DATA_W-1:0]          tx_data,
   input logic                       tx_last,
   input logic                       tx_crc_req,
   input logic                       rsp_valid,
   input logic [1:0]                 rsp_kind,
   input logic                       ev_raw,
   input logic                       ev_pend_clr,
   input logic                       stat_pend,
   input logic [$clog2(DEPTH+1)-1:0] fifo_count,
   input logic                       armed_q
);
   // R3: a byte waiting on the serializer stays put
   a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

   // R3: CRC request follows acceptance of the final byte
   a_r3_crc_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && tx_last |=> tx_crc_req);

   // R4: ACK frees the buffer, disarms and leaves an event pending
   a_r4_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
      ev_raw |=> (fifo_count == '0) && !armed_q && stat_pend);

   // R1: occupancy never exceeds capacity
   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= ($bits(fifo_count))'(DEPTH));

   // R6: a STALL reply never carries payload
   a_r6_stall_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_kind == 2'b10 |-> !tx_valid);

   // R2: a NAK reply never carries payload
   a_r2_nak_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_kind == 2'b01 |-> !tx_valid);

   // R9: pending stays set until cleared
   a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stat_pend && !ev_pend_clr |=> stat_pend);

   // R10: payload only flows for an armed packet
   a_r10_tx_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> armed_q);
endmodule

bind usb_in_tx usb_in_tx_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .tx_data     (tx_data),
   .tx_last     (tx_last),
   .tx_crc_req  (tx_crc_req),
   .rsp_valid   (rsp_valid),
   .rsp_kind    (rsp_kind),
   .ev_raw      (ev_raw),
   .ev_pend_clr (ev_pend_clr),
   .stat_pend   (stat_pend),
   .fifo_count  (fifo_count),
   .armed_q     (armed_q)
);

// File: tb/usb_in_tx_tb.sv
module usb_in_tx_tb;
   localparam logic [1:0] K_NAK   = 2'b01;
   localparam logic [1:0] K_STALL = 2'b10;
   localparam logic [1:0] K_DATA  = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_data_we = 0, sw_ctrl_we = 0, sw_ctrl_stall = 0, sw_ctrl_flush = 0;
   logic [7:0] sw_data = '0;
   logic [3:0] sw_ctrl_ep = '0, tok_ep = '0;
   logic       ev_pend_clr = 0, ev_en_we = 0, ev_en_d = 0;
   logic       tok_in_valid = 0, tok_setup_valid = 0;
   logic       tx_ready = 1'b1, hs_ack = 0, hs_timeout = 0;
   logic       stat_idle, stat_have, stat_pend, ev_raw, irq;
   logic       rsp_valid, tx_valid, tx_last, tx_crc_req;
   logic [1:0] rsp_kind;
   logic [7:0] tx_data;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit rand_ready = 0;
   logic [7:0] lfsr = 8'hA5;

   logic [7:0] model_q[$];
   logic [7:0] exp_q[$];
   bit         exp_last_q[$];
   logic [1:0] exp_rsp_q[$];

   always #4 clk = ~clk;

   usb_in_tx u_dut (
      .clk(clk), .rst_n(rst_n),
      .sw_data_we(sw_data_we), .sw_data(sw_data),
      .sw_ctrl_we(sw_ctrl_we), .sw_ctrl_ep(sw_ctrl_ep),
      .sw_ctrl_stall(sw_ctrl_stall), .sw_ctrl_flush(sw_ctrl_flush),
      .ev_pend_clr(ev_pend_clr), .ev_en_we(ev_en_we), .ev_en_d(ev_en_d),
      .stat_idle(stat_idle), .stat_have(stat_have), .stat_pend(stat_pend),
      .ev_raw(ev_raw), .irq(irq),
      .tok_in_valid(tok_in_valid), .tok_setup_valid(tok_setup_valid), .tok_ep(tok_ep),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_last(tx_last), .tx_crc_req(tx_crc_req),
      .hs_ack(hs_ack), .hs_timeout(hs_timeout)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   // serializer backpressure, changed away from the sampling edge
   always begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready = rand_ready ? lfsr[0] : 1'b1;
   end

   // monitor: compare replies and payload against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_rsp_q.size() == 0) begin
            chk(32'(rsp_kind), 32'hF, "R10 unexpected reply");
         end else begin
            chk(32'(rsp_kind), 32'(exp_rsp_q.pop_front()), "R2/R3/R6 reply kind");
         end
      end
      if (rst_n && tx_valid && tx_ready) begin
         if (exp_q.size() == 0) begin
            chk(32'(tx_data), 32'hFFFF, "R3 unexpected byte");
         end else begin
            chk(32'(tx_data), 32'(exp_q.pop_front()), "R3 payload byte");
            chk(32'(tx_last), 32'(exp_last_q.pop_front()), "R3 last flag");
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_byte(input logic [7:0] b, input bit accepted);
      sw_data_we = 1; sw_data = b;
      tick();
      sw_data_we = 0;
      if (accepted) model_q.push_back(b);
   endtask

   task automatic ctrl(input logic [3:0] ep, input bit stall, input bit flush);
      sw_ctrl_we = 1; sw_ctrl_ep = ep; sw_ctrl_stall = stall; sw_ctrl_flush = flush;
      tick();
      sw_ctrl_we = 0; sw_ctrl_stall = 0; sw_ctrl_flush = 0;
      if (flush) model_q.delete();
   endtask

   task automatic token(input logic [3:0] ep, input logic [1:0] kind);
      exp_rsp_q.push_back(kind);
      if (kind == K_DATA) begin
         foreach (model_q[i]) begin
            exp_q.push_back(model_q[i]);
            exp_last_q.push_back(i == model_q.size() - 1);
         end
      end
      tok_in_valid = 1; tok_ep = ep;
      tick();
      tok_in_valid = 0;
   endtask

   task automatic setup_tok(input logic [3:0] ep);
      tok_setup_valid = 1; tok_ep = ep;
      tick();
      tok_setup_valid = 0;
   endtask

   // wait for the CRC request, optionally poke a token, then handshake
   task automatic finish_pkt(input bit ack, input bit poke);
      bit seen = 0;
      for (int i = 0; i < 2000 && !seen; i++) begin
         @(negedge clk);
         if (tx_crc_req) seen = 1;
      end
      chk(32'(seen), 32'd1, "R3 crc request");
      chk(32'(exp_q.size()), 32'd0, "R3 all bytes sent");
      tick();
      if (poke) begin
         tok_in_valid = 1; tok_ep = 4'd0;
         tick();
         tok_in_valid = 0;
         @(negedge clk);
         chk(32'(rsp_valid), 32'd0, "R10 token ignored while waiting");
         #1;
      end
      if (ack) hs_ack = 1; else hs_timeout = 1;
      tick();
      hs_ack = 0; hs_timeout = 0;
      if (ack) model_q.delete();
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      settle(3);
      rst_n = 1;
      tick();
      @(negedge clk);
      chk(32'(stat_idle), 32'd1, "R11 idle after reset");
      chk(32'(stat_have), 32'd0, "R11 have after reset");
      chk(32'(stat_pend), 32'd0, "R11 pend after reset");
      chk(32'(irq), 32'd0, "R11 irq after reset");
      chk(32'({rsp_valid, tx_valid}), 32'd0, "R11 no output after reset");
      tick();

      // R2: nothing armed
      token(4'd0, K_NAK);
      settle(2);

      // R1: HAVE follows the first byte
      wr_byte(8'h11, 1);
      @(negedge clk);
      chk(32'(stat_have), 32'd1, "R1 have after write");
      #1;
      wr_byte(8'h22, 1);
      wr_byte(8'h33, 1);
      ctrl(4'd2, 0, 0);
      @(negedge clk);
      chk(32'(stat_idle), 32'd0, "R6 armed clears idle");
      #1;
      token(4'd5, K_NAK);               // R2: other endpoint
      settle(2);

      // R5: timeout keeps the packet; retransmit under backpressure
      rand_ready = 1;
      token(4'd2, K_DATA);
      finish_pkt(0, 0);
      @(negedge clk);
      chk(32'({stat_have, stat_idle, stat_pend}), 32'b100, "R5 kept after timeout");
      #1;
      token(4'd2, K_DATA);
      finish_pkt(1, 0);
      rand_ready = 0;
      @(negedge clk);
      chk(32'({stat_have, stat_idle, stat_pend}), 32'b011, "R4 freed after ack");
      chk(32'(irq), 32'd0, "R9 irq masked");
      #1;
      ev_en_we = 1; ev_en_d = 1;
      tick();
      ev_en_we = 0;
      @(negedge clk);
      chk(32'(irq), 32'd1, "R9 irq enabled");
      #1;
      ev_pend_clr = 1;
      tick();
      ev_pend_clr = 0;
      @(negedge clk);
      chk(32'({stat_pend, irq}), 32'd0, "R9 pending cleared");
      #1;
      token(4'd2, K_NAK);               // R4: disarmed after ack
      settle(2);

      // R3: zero-length packet
      ctrl(4'd1, 0, 0);
      token(4'd1, K_DATA);
      finish_pkt(1, 0);
      settle(1);

      // R6 / R7: stall, priority over armed data, cleared by SETUP
      ctrl(4'd3, 1, 0);
      token(4'd3, K_STALL);
      settle(2);
      wr_byte(8'h44, 1);
      ctrl(4'd3, 0, 0);
      ctrl(4'd3, 1, 0);
      token(4'd3, K_STALL);
      settle(2);
      setup_tok(4'd3);
      token(4'd3, K_DATA);
      finish_pkt(1, 0);
      settle(1);

      // R10: write while armed is dropped, token while waiting ignored
      wr_byte(8'h55, 1);
      ctrl(4'd6, 0, 0);
      wr_byte(8'h66, 0);
      token(4'd6, K_DATA);
      finish_pkt(1, 1);
      settle(1);

      // R8: flush empties and disarms
      wr_byte(8'h77, 1);
      ctrl(4'd7, 0, 0);
      ctrl(4'd0, 0, 1);
      @(negedge clk);
      chk(32'({stat_have, stat_idle}), 32'b01, "R8 flush empties");
      #1;
      token(4'd7, K_NAK);
      settle(2);

      // R1: capacity limit
      for (int i = 0; i < 66; i++) wr_byte(8'(i + 8'h80), i < 64);
      ctrl(4'd9, 0, 0);
      token(4'd9, K_DATA);
      finish_pkt(1, 0);
      settle(1);

      // R6: stall set then cleared by a control write
      ctrl(4'd10, 1, 0);
      ctrl(4'd10, 0, 0);
      token(4'd10, K_DATA);
      finish_pkt(1, 0);
      settle(2);

      chk(32'(exp_rsp_q.size()), 32'd0, "R2 all replies seen");
      summary();
   end
endmodule